// File: doc/BRIEF.md
# Ferroelectric Cell Access Sequencer

This block is the digital timing controller for a multi-level ferroelectric memory array in which groups of cells share one gain transistor and one reset transistor. It accepts a request with a row address, a write flag and a 3-bit level. It then steps the array and sense-amplifier controls through fixed phases and ends with a one-cycle done pulse and a 3-bit result. Analog levels, the array and the comparator bank are outside the block. They appear here only as enables, a switch vector, a reference-select code and a 3-bit quantised sense input.

A write drives the level onto the cell. It then clears the gain-transistor gate through the reset line. A read also starts with the reset phase, and the sense amplifier's offset-cancel and precharge steps run inside that phase, so they cost no extra cycles. The cell is then read with the low plate level and the sensed value is evaluated. Reads do not disturb the stored polarisation, so no write-back step follows a read. Every pair of adjacent phases is separated by at least one cycle with all controls off.

Top module: `fe_access_seq`

## Requirements
- R1: While rst_ni is low and after it is released with no request, busy_o, done_o, wl_o, rl_o, pl_wr_o, sl_wr_o, pl_rd_o, sa_sw_o and ref_sel_o are all 0.
- R2: A write (we_i=1) starts with a drive phase in the cycle after acceptance. In this phase wl_o and rl_o are 1. pl_wr_o=1 when level bit 2 is 1; otherwise sl_wr_o=1. The phase lasts T_WSTEP*m cycles, with m=level-3 for levels 4..7 and m=4-level for levels 0..3.
- R3: The drive phase of a write is followed by a reset phase: two segments of T_OC and T_PC cycles in which only rl_o is 1 and wl_o is 0. No further array phase follows.
- R4: A read (we_i=0) has no drive phase and no write-back. Its readout phase lasts T_SMP cycles with wl_o=1, pl_rd_o=1, rl_o=0, pl_wr_o=0 and sl_wr_o=0. It is followed by an evaluate phase of T_EV cycles and then done.
- R5: On a read, the sa_sw_o bits are 0 pull-up set, 1 pull-down set, 2 feedback, 3 feedback-bar, 4 ground, 5 bit-line. They are closed in this order: offset cancel {0,1,2}, precharge {3,4}, sample {3,5}, evaluate {0,1,3}.
- R6: On a read, offset cancel coincides with the first reset segment (T_OC cycles) and precharge with the second (T_PC cycles), both with rl_o=1.
- R7: ref_sel_o equals 2*level+1 throughout the readout phase of a read and is 0 at all other times.
- R8: Bits 2 and 3 of sa_sw_o are never 1 together. Bits 0 and 1 are never closed with bits 4 and 5. Any two successive phases are separated by at least one cycle in which all array and switch outputs are 0.
- R9: busy_o is 1 from the cycle after acceptance through the done cycle. Requests, level_i and row_i are ignored while busy_o is 1. row_o holds the accepted row.
- R10: done_o is a one-cycle pulse. In that cycle data_o shows sense_i as sampled on the last evaluate cycle for a read, or the written level for a write. data_o holds until the next done.
- R11: Each operation, including its done cycle, takes at most OP_NS/CLK_NS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| row_i | input | ROW_W | Row address |
| level_i | input | 3 | Level to write, or reference level for a read |
| sense_i | input | 3 | Quantised comparator result |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| data_o | output | 3 | Result level |
| row_o | output | ROW_W | Latched row select |
| wl_o | output | 1 | Word-line enable |
| rl_o | output | 1 | Reset-line enable |
| pl_wr_o | output | 1 | Plate-line write pulse |
| sl_wr_o | output | 1 | Source-line write pulse |
| pl_rd_o | output | 1 | Plate-line low read level |
| sa_sw_o | output | 6 | Sense-amplifier switches closed |
| ref_sel_o | output | REF_W | Reference-select code |

## Verification
A wrong state or timer value shows at the ports in the same cycle. It appears as an output pattern that runs for the wrong number of cycles, a missing all-off gap, or a switch set in the wrong order. The bench therefore compares each contiguous run of output patterns against the expected phase list, so an error is reported at the first run that closes wrong. A wrong latched level or row shows at the drive or readout phase, and at the done cycle through data_o and row_o. Spurious acceptance while busy shows either as a disturbed run or as an extra operation after done.

// File: rtl/fe_seq_pkg.sv
package fe_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WR, S_OC, S_PC, S_SMP, S_EV, S_GAP, S_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    PH_OFF, PH_OC, PH_PC, PH_SMP, PH_EV
  } sa_phase_e;

  localparam int NUM_SW = 6;
  localparam int SW_PUP = 0;
  localparam int SW_NDN = 1;
  localparam int SW_FB  = 2;
  localparam int SW_FBB = 3;
  localparam int SW_GND = 4;
  localparam int SW_BL  = 5;

  localparam logic [NUM_SW-1:0] MASK_OC  = (1 << SW_PUP) | (1 << SW_NDN) | (1 << SW_FB);
  localparam logic [NUM_SW-1:0] MASK_PC  = (1 << SW_FBB) | (1 << SW_GND);
  localparam logic [NUM_SW-1:0] MASK_SMP = (1 << SW_FBB) | (1 << SW_BL);
  localparam logic [NUM_SW-1:0] MASK_EV  = (1 << SW_PUP) | (1 << SW_NDN) | (1 << SW_FBB);
endpackage

// File: rtl/fe_phase_timer.sv
module fe_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R11: an expired timer stays expired until reloaded
  a_r11_timer_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/fe_sa_switch.sv
module fe_sa_switch
  import fe_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sa_phase_e         phase_i,
  output logic [NUM_SW-1:0] sw_o
);
  for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
    always_comb begin
      unique case (phase_i)
        PH_OC:   sw_o[g] = MASK_OC[g];
        PH_PC:   sw_o[g] = MASK_PC[g];
        PH_SMP:  sw_o[g] = MASK_SMP[g];
        PH_EV:   sw_o[g] = MASK_EV[g];
        default: sw_o[g] = 1'b0;
      endcase
    end
  end

  // R8: feedback and its complement never closed together
  a_r8_fb_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_o[SW_FB] && sw_o[SW_FBB]));
  // R8: latch drivers never fight ground or bit-line paths
  a_r8_drive_vs_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((sw_o[SW_PUP] || sw_o[SW_NDN]) && (sw_o[SW_GND] || sw_o[SW_BL])));
endmodule

// File: rtl/fe_access_seq.sv
module fe_access_seq
  import fe_seq_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int REF_W   = 4,
  parameter int CLK_NS  = 5,
  parameter int OP_NS   = 100,
  parameter int T_WSTEP = 2,
  parameter int T_OC    = 3,
  parameter int T_PC    = 2,
  parameter int T_SMP   = 4,
  parameter int T_EV    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [2:0]        level_i,
  input  logic [2:0]        sense_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        data_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              wl_o,
  output logic              rl_o,
  output logic              pl_wr_o,
  output logic              sl_wr_o,
  output logic              pl_rd_o,
  output logic [NUM_SW-1:0] sa_sw_o,
  output logic [REF_W-1:0]  ref_sel_o
);
  localparam int OP_CYC = OP_NS / CLK_NS;
  localparam int TMR_W  = $clog2(OP_CYC + 1);

  seq_state_e       state_q, state_d, after_q, after_d;
  logic             is_rd_q;
  logic [2:0]       lvl_q;
  logic [2:0]       data_q;
  logic [ROW_W-1:0] row_q;
  logic             load;
  logic [TMR_W-1:0] load_val;
  logic             tmr_zero;
  sa_phase_e        sa_ph;

  function automatic logic [TMR_W-1:0] wr_len(input logic [2:0] lvl);
    logic [2:0] mag;
    mag = lvl[2] ? (lvl - 3'd3) : (3'd4 - lvl);
    return TMR_W'(T_WSTEP * int'(mag));
  endfunction

  function automatic logic [TMR_W-1:0] ph_len(input seq_state_e s);
    case (s)
      S_OC:    return TMR_W'(T_OC);
      S_PC:    return TMR_W'(T_PC);
      S_SMP:   return TMR_W'(T_SMP);
      S_EV:    return TMR_W'(T_EV);
      default: return TMR_W'(1);
    endcase
  endfunction

  always_comb begin
    state_d  = state_q;
    after_d  = after_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        load = 1'b1;
        if (we_i) begin
          state_d  = S_WR;
          load_val = wr_len(level_i) - 1'b1;
        end else begin
          state_d  = S_OC;
          load_val = ph_len(S_OC) - 1'b1;
        end
      end
      S_WR:  if (tmr_zero) begin state_d = S_GAP; after_d = S_OC; end
      S_OC:  if (tmr_zero) begin state_d = S_GAP; after_d = S_PC; end
      S_PC:  if (tmr_zero) begin
        if (is_rd_q) begin state_d = S_GAP; after_d = S_SMP; end
        else state_d = S_DONE;
      end
      S_SMP: if (tmr_zero) begin state_d = S_GAP; after_d = S_EV; end
      S_EV:  if (tmr_zero) state_d = S_DONE;
      S_GAP: begin
        state_d  = after_q;
        load     = 1'b1;
        load_val = ph_len(after_q) - 1'b1;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      after_q <= S_IDLE;
      is_rd_q <= 1'b0;
      lvl_q   <= '0;
      row_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
      if (state_q == S_IDLE && req_i) begin
        is_rd_q <= !we_i;
        lvl_q   <= level_i;
        row_q   <= row_i;
      end
      if (state_d == S_DONE && state_q != S_DONE)
        data_q <= is_rd_q ? sense_i : lvl_q;
    end
  end

  fe_phase_timer #(.W(TMR_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (load_val),
    .zero_o (tmr_zero)
  );

  always_comb begin
    sa_ph = PH_OFF;
    case (state_q)
      S_OC:  if (is_rd_q) sa_ph = PH_OC;
      S_PC:  if (is_rd_q) sa_ph = PH_PC;
      S_SMP: sa_ph = PH_SMP;
      S_EV:  sa_ph = PH_EV;
      default: sa_ph = PH_OFF;
    endcase
  end

  fe_sa_switch i_sa_sw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (sa_ph),
    .sw_o    (sa_sw_o)
  );

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign data_o    = data_q;
  assign row_o     = row_q;
  assign wl_o      = (state_q == S_WR) || (state_q == S_SMP);
  assign rl_o      = (state_q == S_WR) || (state_q == S_OC) || (state_q == S_PC);
  assign pl_wr_o   = (state_q == S_WR) && lvl_q[2];
  assign sl_wr_o   = (state_q == S_WR) && !lvl_q[2];
  assign pl_rd_o   = (state_q == S_SMP);
  assign ref_sel_o = (state_q == S_SMP) ? REF_W'({lvl_q, 1'b1}) : '0;

  // op-length watch for R11
  logic [TMR_W-1:0] op_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        op_cnt_q <= '0;
    else if (!busy_o)                   op_cnt_q <= '0;
    else if (op_cnt_q != {TMR_W{1'b1}}) op_cnt_q <= op_cnt_q + 1'b1;
  end

  logic [NUM_SW+4:0] act_sig;
  assign act_sig = {wl_o, rl_o, pl_wr_o, sl_wr_o, pl_rd_o, sa_sw_o};

  a_r11_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(op_cnt_q) < OP_CYC));
  a_r2_drive_with_wl_rl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pl_wr_o || sl_wr_o) |-> (wl_o && rl_o && !pl_rd_o));
  a_r4_read_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pl_rd_o |-> (!rl_o && !pl_wr_o && !sl_wr_o));
  a_r8_break_before_make: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sig != '0 && $past(act_sig) != '0) |-> (act_sig == $past(act_sig)));
  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(data_o));
  a_r5_eval_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sa_sw_o[SW_PUP] && sa_sw_o[SW_FBB]) |-> $past(sa_sw_o[SW_BL], 2));
endmodule

// File: tb/test_fe_access_seq.sv
module test_fe_access_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 8;
  localparam int REF_W = 4;
  localparam int OP_CYC = 20;
  localparam int TW = 2, TOC = 3, TPC = 2, TSMP = 4, TEV = 2;
  localparam int SIG_W = 5 + 6 + REF_W;
  // switch masks per R5: bit0 pull-up, 1 pull-down, 2 fb, 3 fb-bar, 4 gnd, 5 bl
  localparam logic [5:0] M_OC = 6'b000111, M_PC = 6'b011000,
                         M_SMP = 6'b101000, M_EV = 6'b001011;

  typedef struct { logic [SIG_W-1:0] sig; int len; string tag; } run_t;
  typedef struct { logic [2:0] data; logic [ROW_W-1:0] row; string tag; } res_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [ROW_W-1:0] row_i = '0;
  logic [2:0] level_i = '0, sense_i = '0;
  logic busy_o, done_o, wl_o, rl_o, pl_wr_o, sl_wr_o, pl_rd_o;
  logic [2:0] data_o;
  logic [ROW_W-1:0] row_o;
  logic [5:0] sa_sw_o;
  logic [REF_W-1:0] ref_sel_o;

  int checks = 0, errors = 0, cyc = 0;
  run_t exp_q[$];
  res_t res_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fe_access_seq i_fe_access_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .row_i, .level_i, .sense_i,
    .busy_o, .done_o, .data_o, .row_o, .wl_o, .rl_o, .pl_wr_o,
    .sl_wr_o, .pl_rd_o, .sa_sw_o, .ref_sel_o
  );

  function automatic logic [SIG_W-1:0] mk(logic wl, logic rl, logic plw, logic slw,
                                          logic plr, logic [5:0] sw, logic [REF_W-1:0] rf);
    return {wl, rl, plw, slw, plr, sw, rf};
  endfunction

  logic [SIG_W-1:0] cur_sig;
  assign cur_sig = mk(wl_o, rl_o, pl_wr_o, sl_wr_o, pl_rd_o, sa_sw_o, ref_sel_o);

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push_run(logic [SIG_W-1:0] s, int n, string tag);
    run_t r; r.sig = s; r.len = n; r.tag = tag; exp_q.push_back(r);
  endtask

  // monitor: collapse outputs into runs and compare against scoreboard
  bit in_op = 0;
  logic [SIG_W-1:0] run_sig;
  int run_len = 0, op_len = 0;

  task automatic close_run();
    run_t e;
    if (exp_q.size() == 0) begin
      check(0, "R9", "unexpected run", int'(run_sig), 0);
      return;
    end
    e = exp_q.pop_front();
    check(run_sig == e.sig, e.tag, "run pattern", int'(run_sig), int'(e.sig));
    check(run_len == e.len, e.tag, "run length", run_len, e.len);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (busy_o) begin
        op_len++;
        if (done_o) begin
          res_t r;
          if (in_op) close_run();
          in_op = 0;
          check(cur_sig == '0, "R8", "done cycle outputs", int'(cur_sig), 0);
          check(op_len <= OP_CYC, "R11", "op cycles", op_len, OP_CYC);
          if (res_q.size() == 0) check(0, "R9", "unexpected done", 1, 0);
          else begin
            r = res_q.pop_front();
            check(data_o == r.data, r.tag, "data_o", data_o, r.data);
            check(row_o == r.row, "R9", "row_o", row_o, r.row);
          end
          op_len = 0;
        end else if (!in_op) begin
          in_op = 1; run_sig = cur_sig; run_len = 1;
        end else if (cur_sig == run_sig) run_len++;
        else begin
          close_run(); run_sig = cur_sig; run_len = 1;
        end
      end else begin
        if (cur_sig != '0 || done_o)
          check(0, "R1", "idle outputs", int'(cur_sig), 0);
      end
    end
  end

  // driver: issue one op, push expectations, optionally spam while busy
  task automatic do_op(bit we, logic [2:0] lvl, logic [ROW_W-1:0] row,
                       logic [2:0] sns, bit spam);
    res_t r;
    logic [REF_W-1:0] rf;
    int m;
    @(negedge clk_i);
    if (we) begin
      m = lvl[2] ? int'(lvl) - 3 : 4 - int'(lvl);
      push_run(mk(1, 1, lvl[2], !lvl[2], 0, '0, '0), TW * m, "R2");
      push_run('0, 1, "R8");
      push_run(mk(0, 1, 0, 0, 0, '0, '0), TOC, "R3");
      push_run('0, 1, "R8");
      push_run(mk(0, 1, 0, 0, 0, '0, '0), TPC, "R3");
      r.data = lvl; r.tag = "R10";
    end else begin
      rf = REF_W'(2 * int'(lvl) + 1);
      push_run(mk(0, 1, 0, 0, 0, M_OC, '0), TOC, "R6");
      push_run('0, 1, "R8");
      push_run(mk(0, 1, 0, 0, 0, M_PC, '0), TPC, "R6");
      push_run('0, 1, "R8");
      push_run(mk(1, 0, 0, 0, 1, M_SMP, rf), TSMP, "R4 R7");
      push_run('0, 1, "R8");
      push_run(mk(0, 0, 0, 0, 0, M_EV, '0), TEV, "R5");
      r.data = sns; r.tag = "R10";
    end
    r.row = row;
    res_q.push_back(r);
    req_i = 1; we_i = we; level_i = lvl; row_i = row; sense_i = sns;
    @(negedge clk_i);
    req_i = 0;
    if (spam) begin
      for (int k = 0; k < 4; k++) begin
        req_i = 1; we_i = ~we; level_i = ~lvl; row_i = ~row;
        @(negedge clk_i);
      end
      req_i = 0;
    end
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    check(!busy_o && !done_o, "R10", "done single cycle", {busy_o, done_o}, 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check(!busy_o && !done_o && cur_sig == '0, "R1", "reset outputs",
          int'({busy_o, done_o, cur_sig}), 0);
    @(negedge clk_i); rst_ni = 1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && cur_sig == '0, "R1", "post-reset idle", int'(cur_sig), 0);

    do_op(1, 3'd7, 8'h11, 3'd0, 0);
    do_op(1, 3'd0, 8'h22, 3'd0, 0);
    do_op(1, 3'd4, 8'h33, 3'd0, 0);
    do_op(1, 3'd3, 8'h44, 3'd0, 0);
    do_op(0, 3'd5, 8'h55, 3'd6, 0);
    do_op(0, 3'd0, 8'h66, 3'd1, 0);
    do_op(0, 3'd7, 8'h77, 3'd2, 1);
    do_op(1, 3'd6, 8'h88, 3'd0, 1);
    check(data_o == 3'd6, "R10", "data hold after done", data_o, 6);
    do_op(0, 3'd3, 8'h99, 3'd5, 0);

    repeat (5) @(negedge clk_i);
    check(!busy_o, "R9", "no op from ignored requests", busy_o, 0);
    check(exp_q.size() == 0 && res_q.size() == 0, "R9", "scoreboard drained",
          exp_q.size() + res_q.size(), 0);
    check(data_o == 3'd5, "R10", "data held while idle", data_o, 5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule